// File: doc/BRIEF.md
# Register-Access Serial Bus Slave

This block is a two-wire serial bus slave that lets an external master read and write an internal bank of 8-bit registers. It oversamples the open-drain clock and data lines with the system clock, spots START and STOP conditions, and shifts bytes most significant bit first. It also matches the first byte after START against its own device address and answers by pulling the data line low.

A write transaction carries a register sub-address and then any number of data bytes. A read transaction carries no sub-address. It returns bytes starting from an internal pointer that was left behind by earlier traffic. The pointer advances after every data byte in either direction, and it keeps its value across STOP. A long burst therefore moves the starting point of the next read.

The device address is taken once from three select straps and a multi-device strap, on the first clock after reset is released.

Top module: `regbus_slave`

## Requirements
- R1: After reset, and on the cycle after any START or STOP is seen, the slave does not pull SDA low.
- R2: With the multi-device strap low, the slave answers only to 0xC0 (write) and 0xC1 (read), whatever the select straps are.
- R3: With the multi-device strap high, the write address is 0xC0 + 4 × select and the read address is that value plus one.
- R4: The straps are captured on the first clock after reset is released; later changes have no effect until the next reset.
- R5: The first byte after START arrives MSB first, and its bit 0 is the direction (0 write, 1 read). On a match the slave pulls SDA low for the ninth clock. On a mismatch it never pulls SDA until the next START or STOP.
- R6: In a write, the byte after the address loads the pointer. Each later byte is acknowledged and stored at the pointer, which then increments.
- R7: A read returns the register at the pointer, MSB first, and the pointer increments after each byte.
- R8: The pointer keeps its value across STOP, so the next read continues where the last transfer ended.
- R9: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing more until START or STOP.
- R10: A START inside a transaction aborts it. A partly shifted byte is not stored, and address matching starts afresh.
- R11: The pointer wraps from 0xFF to 0x00.
- R12: The slave begins pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed level of the serial clock line |
| sda_i | input | 1 | Sensed level of the serial data line |
| sda_pull_o | output | 1 | 1 = pull the data line low, 0 = release it |
| strap_sel_i | input | 3 | Address select straps |
| strap_multi_i | input | 1 | Multi-device strap; 1 enables the select straps |

## Verification
On every cycle, the assertions check the following:
- SDA is released after START and STOP.
- A pull on SDA only begins while SCL is low.
- The captured address never moves after capture.
- A write strobe lasts one cycle.
- The slave stays silent after a master not-acknowledge.

Only the bench scenarios can show the rest:
- Which addresses the straps select.
- That data lands in the right registers and comes back in order.
- That the pointer survives STOP and wraps.
- That an aborted byte is dropped.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_SUB,
      ST_WR,
      ST_RD,
      ST_SKIP
   } bus_state_e;
endpackage

// File: rtl/regbus_sync.sv
module regbus_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("regbus_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/regbus_strap.sv
module regbus_strap #(
   parameter logic [7:0] BASE_ADDR = 8'hC0,
   parameter int         ADDR_STEP = 4,
   parameter bit         MULTI_OK  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] sel_i,
   input  logic       multi_i,
   output logic [6:0] dev_addr_o
);
   localparam logic [6:0] BASE7 = BASE_ADDR[7:1];
   localparam int         STEP7 = ADDR_STEP / 2;

   generate
      if (BASE_ADDR[0] != 1'b0 || (ADDR_STEP % 2) != 0) begin : g_bad_base
         $error("regbus_strap: base and step must be even");
      end
      if (int'(BASE_ADDR) + 7 * ADDR_STEP > 254) begin : g_bad_range
         $error("regbus_strap: address range exceeds 8 bits");
      end
   endgenerate

   logic [6:0] pick;

   generate
      if (MULTI_OK) begin : g_multi
         always_comb pick = multi_i ? 7'(int'(BASE7) + int'(sel_i) * STEP7) : BASE7;
      end else begin : g_single
         logic unused_straps;
         assign unused_straps = ^{sel_i, multi_i};
         always_comb pick = BASE7;
      end
   endgenerate

   logic       cap_q;
   logic [6:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q  <= 1'b0;
         addr_q <= BASE7;
      end else if (!cap_q) begin
         cap_q  <= 1'b1;
         addr_q <= pick;
      end
   end

   assign dev_addr_o = addr_q;

   // R4: once captured, the address never changes until reset
   p_strap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_q && $past(cap_q)) |-> $stable(addr_q));
endmodule

// File: rtl/regbus_regfile.sv
module regbus_regfile #(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic [AW-1:0] raddr_i,
   output logic [DW-1:0] rdata_o
);
   localparam int DEPTH = 1 << AW;

   generate
      if (AW < 1 || AW > 8) begin : g_bad_aw
         $error("regbus_regfile: AW must be 1..8");
      end
   endgenerate

   logic [DW-1:0] mem_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (we_i) begin
         mem_q[waddr_i] <= wdata_i;
      end
   end

   assign rdata_o = mem_q[raddr_i];

   // R6: each received byte produces a single-cycle write strobe
   p_we_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> !we_i);
endmodule

// File: rtl/regbus_slave.sv
module regbus_slave
   import regbus_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter int         REG_AW      = 8,
   parameter logic [7:0] BASE_ADDR   = 8'hC0,
   parameter int         ADDR_STEP   = 4,
   parameter bit         MULTI_OK    = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_pull_o,
   input  logic [2:0] strap_sel_i,
   input  logic       strap_multi_i
);
   localparam int CNT_W = $clog2(BYTE_W + 1);

   generate
      if (REG_AW > BYTE_W) begin : g_bad_aw
         $error("regbus_slave: REG_AW cannot exceed one byte");
      end
   endgenerate

   logic scl_s, sda_s, scl_q, sda_q;

   regbus_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s));
   regbus_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   logic start_det, stop_det, scl_rise, scl_fall;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;

   logic [6:0] dev_addr;

   regbus_strap #(.BASE_ADDR(BASE_ADDR), .ADDR_STEP(ADDR_STEP), .MULTI_OK(MULTI_OK)) u_strap (
      .clk(clk), .rst_n(rst_n), .sel_i(strap_sel_i), .multi_i(strap_multi_i),
      .dev_addr_o(dev_addr));

   bus_state_e         state_q;
   logic [CNT_W-1:0]   bitcnt_q;
   logic               ack_slot_q;
   logic               pull_q;
   logic               rw_q;
   logic               mack_q;
   logic [BYTE_W-1:0]  shreg_q;
   logic [BYTE_W-1:0]  tx_q;
   logic [REG_AW-1:0]  ptr_q;
   logic [BYTE_W-1:0]  rd_data;
   logic               rx_state, byte_done, reg_we;

   assign rx_state  = (state_q == ST_DEV) || (state_q == ST_SUB) || (state_q == ST_WR);
   assign byte_done = rx_state && !ack_slot_q && scl_fall && (bitcnt_q == CNT_W'(BYTE_W));
   assign reg_we    = byte_done && (state_q == ST_WR);

   regbus_regfile #(.AW(REG_AW), .DW(BYTE_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we_i(reg_we), .waddr_i(ptr_q), .wdata_i(shreg_q),
      .raddr_i(ptr_q), .rdata_o(rd_data));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         bitcnt_q   <= '0;
         ack_slot_q <= 1'b0;
         pull_q     <= 1'b0;
         rw_q       <= 1'b0;
         mack_q     <= 1'b0;
         shreg_q    <= '0;
         tx_q       <= '0;
         ptr_q      <= '0;
      end else if (start_det) begin
         state_q    <= ST_DEV;
         bitcnt_q   <= '0;
         ack_slot_q <= 1'b0;
         pull_q     <= 1'b0;
      end else if (stop_det) begin
         state_q    <= ST_IDLE;
         bitcnt_q   <= '0;
         ack_slot_q <= 1'b0;
         pull_q     <= 1'b0;
      end else begin
         case (state_q)
            ST_DEV, ST_SUB, ST_WR: begin
               if (!ack_slot_q) begin
                  if (scl_rise) begin
                     shreg_q  <= {shreg_q[BYTE_W-2:0], sda_s};
                     bitcnt_q <= bitcnt_q + 1'b1;
                  end else if (byte_done) begin
                     bitcnt_q <= '0;
                     if (state_q == ST_DEV) begin
                        if (shreg_q[7:1] == dev_addr) begin
                           rw_q       <= shreg_q[0];
                           ack_slot_q <= 1'b1;
                           pull_q     <= 1'b1;
                        end else begin
                           state_q <= ST_SKIP;
                        end
                     end else begin
                        ack_slot_q <= 1'b1;
                        pull_q     <= 1'b1;
                        if (state_q == ST_SUB) ptr_q <= shreg_q[REG_AW-1:0];
                        else                   ptr_q <= ptr_q + 1'b1;
                     end
                  end
               end else if (scl_fall) begin
                  ack_slot_q <= 1'b0;
                  pull_q     <= 1'b0;
                  if (state_q == ST_DEV) begin
                     if (rw_q) begin
                        state_q <= ST_RD;
                        tx_q    <= rd_data;
                        pull_q  <= ~rd_data[BYTE_W-1];
                     end else begin
                        state_q <= ST_SUB;
                     end
                  end else if (state_q == ST_SUB) begin
                     state_q <= ST_WR;
                  end
               end
            end
            ST_RD: begin
               if (!ack_slot_q) begin
                  if (scl_rise) begin
                     bitcnt_q <= bitcnt_q + 1'b1;
                  end else if (scl_fall) begin
                     if (bitcnt_q == CNT_W'(BYTE_W)) begin
                        pull_q     <= 1'b0;
                        ack_slot_q <= 1'b1;
                        ptr_q      <= ptr_q + 1'b1;
                     end else begin
                        pull_q <= ~tx_q[3'(CNT_W'(BYTE_W - 1) - bitcnt_q)];
                     end
                  end
               end else begin
                  if (scl_rise) begin
                     mack_q <= ~sda_s;
                  end else if (scl_fall) begin
                     ack_slot_q <= 1'b0;
                     bitcnt_q   <= '0;
                     if (mack_q) begin
                        tx_q   <= rd_data;
                        pull_q <= ~rd_data[BYTE_W-1];
                     end else begin
                        state_q <= ST_SKIP;
                        pull_q  <= 1'b0;
                     end
                  end
               end
            end
            default: pull_q <= 1'b0;
         endcase
      end
   end

   assign sda_pull_o = pull_q;

   // R1: bus conditions always release the data line
   p_release_on_cond_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (start_det || stop_det) |=> !sda_pull_o);

   // R5: a non-addressed slave keeps the line free
   p_skip_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SKIP) |-> !sda_pull_o);

   // R9: a master not-acknowledge silences the slave
   p_nack_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RD && ack_slot_q && scl_fall && !mack_q && !start_det && !stop_det)
      |=> (!sda_pull_o && state_q == ST_SKIP));

   // R12: a pull on the data line starts only with the clock low
   p_pull_on_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull_o) |-> !scl_s);
endmodule

// File: tb/regbus_slave_bench.sv
`timescale 1ns/1ps
module regbus_slave_bench;
   localparam time Q = 40ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_pull;
   logic [2:0] sel = 3'd5;
   logic       multi = 1'b0;
   logic       sda_line;

   assign sda_line = sda_m & ~sda_pull;

   always #2ns clk = ~clk;

   regbus_slave u_regbus_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_pull_o(sda_pull), .strap_sel_i(sel), .strap_multi_i(multi));

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   typedef struct {
      logic [7:0] v;
      string      tag;
   } exp_t;
   exp_t       exp_q[$];
   event       rx_ev;
   logic [7:0] rx_byte;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
      end
   endtask

   // monitor: pops expected read bytes as the slave delivers them
   always begin
      @(rx_ev);
      if (exp_q.size() == 0) begin
         check(1'b0, "R7", "unexpected read byte", int'(rx_byte), 0);
      end else begin
         exp_t e;
         e = exp_q.pop_front();
         check(rx_byte == e.v, e.tag, "read byte", int'(rx_byte), int'(e.v));
      end
   end

   task automatic push_exp(input logic [7:0] v, input string tag);
      exp_t e;
      e.v = v;
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0; #Q;
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #Q;
   endtask

   task automatic put_bit(input logic b);
      sda_m = b; #Q; scl_m = 1'b1; #(2*Q); scl_m = 1'b0; #Q;
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) put_bit(b[i]);
      sda_m = 1'b1; #Q; scl_m = 1'b1; #Q;
      ack = !sda_line;
      #Q; scl_m = 1'b0; #Q;
   endtask

   task automatic get_byte(input bit give_ack);
      logic [7:0] b;
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         #Q; scl_m = 1'b1; #Q; b[i] = sda_line; #Q; scl_m = 1'b0; #Q;
      end
      sda_m = give_ack ? 1'b0 : 1'b1;
      #Q; scl_m = 1'b1; #(2*Q); scl_m = 1'b0; #Q;
      sda_m = 1'b1;
      rx_byte = b;
      ->rx_ev;
      #Q;
   endtask

   task automatic do_reset(input logic [2:0] s, input logic m);
      rst_n = 1'b0; sel = s; multi = m;
      scl_m = 1'b1; sda_m = 1'b1;
      #100ns; rst_n = 1'b1; #100ns;
   endtask

   initial begin
      #800us;
      if (!done) begin
         check(1'b0, "R1", "watchdog expired", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      bit ack;
      // session 1: single-address mode, select straps set to 5
      do_reset(3'd5, 1'b0);
      check(sda_pull == 1'b0, "R1", "pull after reset", int'(sda_pull), 0);

      // R2: the select-based address must not answer with multi low
      bus_start(); send_byte(8'hD4, ack);
      check(ack == 1'b0, "R2", "ack to 0xD4", int'(ack), 0);
      put_bit(1'b1);
      check(sda_pull == 1'b0, "R5", "pull after mismatch", int'(sda_pull), 0);
      bus_stop();
      check(sda_pull == 1'b0, "R1", "pull after stop", int'(sda_pull), 0);

      // R5/R6: write burst at 0x10
      bus_start(); send_byte(8'hC0, ack);
      check(ack, "R2", "ack to 0xC0", int'(ack), 1);
      send_byte(8'h10, ack);
      check(ack, "R6", "ack sub-address", int'(ack), 1);
      send_byte(8'hA1, ack); check(ack, "R6", "ack data 0", int'(ack), 1);
      send_byte(8'hB2, ack); check(ack, "R6", "ack data 1", int'(ack), 1);
      send_byte(8'hC3, ack); check(ack, "R6", "ack data 2", int'(ack), 1);
      send_byte(8'hD4, ack); check(ack, "R6", "ack data 3", int'(ack), 1);
      bus_stop();

      // R7: set pointer to 0x10, then read three bytes without sub-address
      bus_start(); send_byte(8'hC0, ack); send_byte(8'h10, ack); bus_stop();
      bus_start(); send_byte(8'hC1, ack);
      check(ack, "R2", "ack to 0xC1", int'(ack), 1);
      push_exp(8'hA1, "R7"); get_byte(1'b1);
      push_exp(8'hB2, "R7"); get_byte(1'b1);
      push_exp(8'hC3, "R7"); get_byte(1'b0);
      // R9: after the not-acknowledge the line stays released
      push_exp(8'hFF, "R9"); get_byte(1'b0);
      bus_stop();

      // R8: pointer continues from 0x13 in a fresh read
      bus_start(); send_byte(8'hC1, ack);
      push_exp(8'hD4, "R8"); get_byte(1'b0);
      bus_stop();

      // R11: wrap from 0xFF to 0x00
      bus_start(); send_byte(8'hC0, ack); send_byte(8'hFE, ack);
      send_byte(8'h11, ack); send_byte(8'h22, ack); send_byte(8'h33, ack);
      check(ack, "R11", "ack at wrapped address", int'(ack), 1);
      bus_stop();
      bus_start(); send_byte(8'hC0, ack); send_byte(8'hFE, ack); bus_stop();
      bus_start(); send_byte(8'hC1, ack);
      push_exp(8'h11, "R11"); get_byte(1'b1);
      push_exp(8'h22, "R11"); get_byte(1'b1);
      push_exp(8'h33, "R11"); get_byte(1'b0);
      bus_stop();

      // R10: START in the middle of a data byte aborts the write
      bus_start(); send_byte(8'hC0, ack); send_byte(8'h40, ack);
      put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
      bus_start(); send_byte(8'hC1, ack);
      check(ack, "R10", "ack after abort", int'(ack), 1);
      push_exp(8'h00, "R10"); get_byte(1'b0);
      bus_stop();

      // session 2: multi-device mode, select 5 -> 0xD4/0xD5
      do_reset(3'd5, 1'b1);
      sel = 3'd0; multi = 1'b0; // R4: changes after capture are ignored
      #200ns;
      bus_start(); send_byte(8'hC0, ack);
      check(ack == 1'b0, "R4", "ack to 0xC0 after strap change", int'(ack), 0);
      bus_stop();
      bus_start(); send_byte(8'hD4, ack);
      check(ack, "R3", "ack to 0xD4", int'(ack), 1);
      send_byte(8'h20, ack); send_byte(8'h77, ack);
      bus_stop();
      bus_start(); send_byte(8'hD4, ack); send_byte(8'h20, ack); bus_stop();
      bus_start(); send_byte(8'hD5, ack);
      check(ack, "R3", "ack to 0xD5", int'(ack), 1);
      push_exp(8'h77, "R3"); get_byte(1'b0);
      bus_stop();
      check(sda_pull == 1'b0, "R12", "line free at end", int'(sda_pull), 0);

      #200ns;
      check(exp_q.size() == 0, "R7", "pending expected bytes", exp_q.size(), 0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule